// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between a CPU bus and an embedded flash array. Software drives the array by writing command codes to one write-only register. That register sits at the highest offset of a 4 KB address page. The controller decodes each code into an array mode. It forwards CPU reads of every other offset to the array, and it turns a CPU write into a program pulse when program mode is selected. Erase and reset carry more risk, so each one needs the same code written twice in a row. A single write is enough for every other command.

Commands are accepted only while software holds the reprogramming select input high and the programming supply is reported ready. A registered monitor flag shows that this condition holds. If either input drops, the controller returns to read mode at once. On the array side the controller gives a mode code, an address, write data and one-cycle strobes for read, program and erase. The array answers with read data and a done pulse.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While `rst` is high, the outputs go to these values on the next clock edge: `arr_mode` is 0 (read), `busy`, `mode_valid`, `cpu_rvalid` and all three array strobes are 0.
- R2: A command write of 0x00, 0x40, 0xC0 or 0xA0 sets `arr_mode` on the next edge to 0, 1, 2 or 4 (read, program, program-verify, erase-verify). A command write is a write to offset all-ones while enabled and not busy.
- R3: A CPU read of any offset except the command offset pulses `arr_rd_stb` with that address on the next edge. One edge later, `cpu_rvalid` is 1 and `cpu_rdata` holds the array data. The mode does not change, however many reads are made.
- R4: A single 0x20 changes nothing. When the command write just before it was also 0x20, a second 0x20 pulses `arr_erase_stb`, sets `arr_mode` to 3 and raises `busy`.
- R5: A single 0xFF changes nothing. When the command write just before it was also 0xFF, a second 0xFF sets `arr_mode` to 0.
- R6: If any other code follows a first 0x20 or 0xFF, the pending half is dropped and the new code is decoded alone. Codes outside the defined set leave `arr_mode` unchanged.
- R7: A read of the command offset returns 0 with `cpu_rvalid` and produces no array read strobe.
- R8: `mode_valid` follows `reprog_sel AND vpp_ok` one edge later. Command writes are ignored while that condition is low.
- R9: When `reprog_sel AND vpp_ok` is low, the next edge sets `arr_mode` to 0, clears `busy` and drops any pending half command.
- R10: In program mode, a write to a flash offset pulses `arr_prog_stb` with its address and data and raises `busy`. Command writes are ignored until `arr_done`. On the edge that samples `arr_done`, `busy` clears and `arr_mode` returns to 0.
- R11: In the verify modes, CPU reads reach the array with `arr_mode` still showing the verify mode, and they return the array data with the same timing as R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | Offset within the flash page |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_rvalid |
| cpu_rvalid | output | 1 | Read data valid, two edges after cpu_rd |
| reprog_sel | input | 1 | Software reprogramming select |
| vpp_ok | input | 1 | Programming supply is at level |
| mode_valid | output | 1 | Reprogramming mode is valid |
| busy | output | 1 | Program or erase in progress |
| arr_mode | output | 3 | Array mode: 0 read, 1 program, 2 program-verify, 3 erase, 4 erase-verify |
| arr_addr | output | ADDR_W | Array address |
| arr_wdata | output | DATA_W | Array program data |
| arr_rd_stb | output | 1 | Array read strobe |
| arr_prog_stb | output | 1 | Program pulse start |
| arr_erase_stb | output | 1 | Erase start |
| arr_rdata | input | DATA_W | Array read data, combinational on arr_addr |
| arr_done | input | 1 | Program or erase finished |

## Verification
Mode changes, strobes and the monitor flag are due one edge after the bus cycle that causes them. Read data is due two edges after `cpu_rd`, and `busy` falls on the edge after the array's done pulse. Each bench task drives its inputs on a falling edge and releases them on the next falling edge. It then samples the strobes and the mode at that falling edge, and the read data one falling edge later, so each check falls half a cycle after the edge that should produce the value. Program and erase completions are awaited by polling `busy` on falling edges, with a bounded count.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    M_READ  = 3'd0,
    M_PROG  = 3'd1,
    M_PVFY  = 3'd2,
    M_ERASE = 3'd3,
    M_EVFY  = 3'd4
  } fmode_e;

  typedef enum logic [1:0] {
    P_NONE  = 2'd0,
    P_ERASE = 2'd1,
    P_RESET = 2'd2
  } fpend_e;

  typedef struct packed {
    logic   load;
    fmode_e mode;
    logic   erase_go;
    fpend_e pend;
  } fdec_t;

  localparam logic [7:0] CODE_READ  = 8'h00;
  localparam logic [7:0] CODE_PROG  = 8'h40;
  localparam logic [7:0] CODE_PVFY  = 8'hC0;
  localparam logic [7:0] CODE_ERASE = 8'h20;
  localparam logic [7:0] CODE_EVFY  = 8'hA0;
  localparam logic [7:0] CODE_RESET = 8'hFF;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
(
  input  logic [7:0] code,
  input  fpend_e     pend_q,
  output fdec_t      dec
);

  always_comb begin
    dec.load     = 1'b0;
    dec.mode     = M_READ;
    dec.erase_go = 1'b0;
    dec.pend     = P_NONE;
    case (code)
      CODE_READ: begin
        dec.load = 1'b1;
        dec.mode = M_READ;
      end
      CODE_PROG: begin
        dec.load = 1'b1;
        dec.mode = M_PROG;
      end
      CODE_PVFY: begin
        dec.load = 1'b1;
        dec.mode = M_PVFY;
      end
      CODE_EVFY: begin
        dec.load = 1'b1;
        dec.mode = M_EVFY;
      end
      CODE_ERASE: begin
        if (pend_q == P_ERASE) dec.erase_go = 1'b1;
        else                   dec.pend     = P_ERASE;
      end
      CODE_RESET: begin
        if (pend_q == P_RESET) begin
          dec.load = 1'b1;
          dec.mode = M_READ;
        end else begin
          dec.pend = P_RESET;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   enabled,
  input  logic   cmd_wr,
  input  fdec_t  dec,
  input  logic   prog_wr,
  input  logic   arr_done,
  output fmode_e mode_q,
  output fpend_e pend_q,
  output logic   busy_q,
  output logic   prog_stb_q,
  output logic   erase_stb_q,
  output logic   valid_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= M_READ;
      pend_q      <= P_NONE;
      busy_q      <= 1'b0;
      prog_stb_q  <= 1'b0;
      erase_stb_q <= 1'b0;
      valid_q     <= 1'b0;
    end else begin
      prog_stb_q  <= 1'b0;
      erase_stb_q <= 1'b0;
      valid_q     <= enabled;
      if (!enabled) begin
        mode_q <= M_READ;
        pend_q <= P_NONE;
        busy_q <= 1'b0;
      end else if (busy_q) begin
        if (arr_done) begin
          busy_q <= 1'b0;
          mode_q <= M_READ;
        end
      end else if (cmd_wr) begin
        pend_q <= dec.pend;
        if (dec.load) mode_q <= dec.mode;
        if (dec.erase_go) begin
          mode_q      <= M_ERASE;
          busy_q      <= 1'b1;
          erase_stb_q <= 1'b1;
        end
      end else if (prog_wr) begin
        prog_stb_q <= 1'b1;
        busy_q     <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/flash_bus_port.sv
module flash_bus_port #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic              rd_arr,
  input  logic              prog_wr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [ADDR_W-1:0] arr_addr_q,
  output logic [DATA_W-1:0] arr_wdata_q,
  output logic              arr_rd_stb_q,
  output logic [DATA_W-1:0] cpu_rdata_q,
  output logic              cpu_rvalid_q
);

  logic rd_pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_addr_q   <= '0;
      arr_wdata_q  <= '0;
      arr_rd_stb_q <= 1'b0;
      rd_pend_q    <= 1'b0;
      cpu_rdata_q  <= '0;
      cpu_rvalid_q <= 1'b0;
    end else begin
      arr_rd_stb_q <= rd_arr;
      rd_pend_q    <= cpu_rd;
      cpu_rvalid_q <= rd_pend_q;
      if (rd_arr || prog_wr) arr_addr_q <= cpu_addr;
      if (prog_wr)           arr_wdata_q <= cpu_wdata;
      if (rd_pend_q)         cpu_rdata_q <= arr_rd_stb_q ? arr_rdata : '0;
    end
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rvalid,
  input  logic              reprog_sel,
  input  logic              vpp_ok,
  output logic              mode_valid,
  output logic              busy,
  output logic [2:0]        arr_mode,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              arr_rd_stb,
  output logic              arr_prog_stb,
  output logic              arr_erase_stb,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic              arr_done
);
  import flash_cmd_pkg::*;

  localparam logic [ADDR_W-1:0] CMD_OFS = {ADDR_W{1'b1}};

  logic   enabled, at_cmd, cmd_wr, prog_wr, rd_arr;
  fmode_e mode_q;
  fpend_e pend_q;
  fdec_t  dec;

  assign enabled = reprog_sel & vpp_ok;
  assign at_cmd  = (cpu_addr == CMD_OFS);
  assign cmd_wr  = cpu_wr & at_cmd & enabled & ~busy;
  assign prog_wr = cpu_wr & ~at_cmd & enabled & ~busy & (mode_q == M_PROG);
  assign rd_arr  = cpu_rd & ~at_cmd & ~busy;

  flash_cmd_decode dec_i (
    .code   (cpu_wdata[7:0]),
    .pend_q (pend_q),
    .dec    (dec)
  );

  flash_cmd_seq seq_i (
    .clk         (clk),
    .rst         (rst),
    .enabled     (enabled),
    .cmd_wr      (cmd_wr),
    .dec         (dec),
    .prog_wr     (prog_wr),
    .arr_done    (arr_done),
    .mode_q      (mode_q),
    .pend_q      (pend_q),
    .busy_q      (busy),
    .prog_stb_q  (arr_prog_stb),
    .erase_stb_q (arr_erase_stb),
    .valid_q     (mode_valid)
  );

  flash_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) port_i (
    .clk          (clk),
    .rst          (rst),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .cpu_rd       (cpu_rd),
    .rd_arr       (rd_arr),
    .prog_wr      (prog_wr),
    .arr_rdata    (arr_rdata),
    .arr_addr_q   (arr_addr),
    .arr_wdata_q  (arr_wdata),
    .arr_rd_stb_q (arr_rd_stb),
    .cpu_rdata_q  (cpu_rdata),
    .cpu_rvalid_q (cpu_rvalid)
  );

  assign arr_mode = mode_q;

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rd,
  input logic              cpu_rvalid,
  input logic              reprog_sel,
  input logic              vpp_ok,
  input logic              mode_valid,
  input logic              busy,
  input logic [2:0]        arr_mode,
  input logic              arr_rd_stb,
  input logic              arr_prog_stb,
  input logic              arr_erase_stb,
  input logic              arr_done
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (arr_mode == 3'd0 && !busy && !mode_valid && !arr_prog_stb && !arr_erase_stb));

  a_r8_flag_follows: assert property (@(posedge clk) disable iff (rst)
    (reprog_sel && vpp_ok) |=> mode_valid);

  a_r9_force_read: assert property (@(posedge clk) disable iff (rst)
    !(reprog_sel && vpp_ok) |=> (arr_mode == 3'd0 && !busy && !mode_valid));

  a_r3_read_latency: assert property (@(posedge clk) disable iff (rst)
    arr_rd_stb |=> cpu_rvalid);

  a_r7_no_cmd_read: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr == {ADDR_W{1'b1}}) |=> !arr_rd_stb);

  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({arr_rd_stb, arr_prog_stb, arr_erase_stb}));

  a_r10_prog_pulse: assert property (@(posedge clk) disable iff (rst)
    arr_prog_stb |=> !arr_prog_stb);

  a_r10_prog_busy: assert property (@(posedge clk) disable iff (rst)
    arr_prog_stb |-> busy);

  a_r10_hold_mode: assert property (@(posedge clk) disable iff (rst)
    (busy && !arr_done && reprog_sel && vpp_ok) |=> $stable(arr_mode));

  a_r4_erase_start: assert property (@(posedge clk) disable iff (rst)
    arr_erase_stb |-> (busy && arr_mode == 3'd3));

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .cpu_addr      (cpu_addr),
  .cpu_rd        (cpu_rd),
  .cpu_rvalid    (cpu_rvalid),
  .reprog_sel    (reprog_sel),
  .vpp_ok        (vpp_ok),
  .mode_valid    (mode_valid),
  .busy          (busy),
  .arr_mode      (arr_mode),
  .arr_rd_stb    (arr_rd_stb),
  .arr_prog_stb  (arr_prog_stb),
  .arr_erase_stb (arr_erase_stb),
  .arr_done      (arr_done)
);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb_top;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] CMD = {ADDR_W{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic reprog_sel = 1'b0, vpp_ok = 1'b0;
  logic [DATA_W-1:0] cpu_rdata, arr_wdata, arr_rdata;
  logic cpu_rvalid, mode_valid, busy, arr_rd_stb, arr_prog_stb, arr_erase_stb;
  logic [2:0] arr_mode;
  logic [ADDR_W-1:0] arr_addr;
  logic arr_done = 1'b0;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .reprog_sel(reprog_sel), .vpp_ok(vpp_ok), .mode_valid(mode_valid), .busy(busy),
    .arr_mode(arr_mode), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .arr_rd_stb(arr_rd_stb), .arr_prog_stb(arr_prog_stb), .arr_erase_stb(arr_erase_stb),
    .arr_rdata(arr_rdata), .arr_done(arr_done)
  );

  // behavioural array: combinational read, program/erase finish after a delay
  logic [7:0] mem [0:DEPTH-1];
  int cnt = 0;
  bit is_erase = 1'b0;
  logic [ADDR_W-1:0] p_addr;
  logic [7:0] p_data;
  assign arr_rdata = mem[arr_addr];

  function automatic logic [7:0] seed(int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  initial for (int i = 0; i < DEPTH; i++) mem[i] = seed(i);

  always @(posedge clk) begin
    arr_done <= 1'b0;
    if (arr_prog_stb || arr_erase_stb) begin
      cnt <= 4; is_erase <= arr_erase_stb; p_addr <= arr_addr; p_data <= arr_wdata;
    end else if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        arr_done <= 1'b1;
        if (is_erase) for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
        else mem[p_addr] = p_data;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic bus_read(logic [ADDR_W-1:0] a, int exp_stb, int exp_data, string req);
    @(negedge clk); cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk); cpu_rd = 1'b0;
    check({req, " rd strobe"}, arr_rd_stb, exp_stb);
    if (exp_stb != 0) check({req, " rd addr"}, arr_addr, a);
    @(negedge clk);
    check({req, " rvalid"}, cpu_rvalid, 1);
    check({req, " rdata"}, cpu_rdata, exp_data);
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    while (busy && n < 50) begin @(negedge clk); n++; end
    check({req, " busy cleared"}, busy, 0);
  endtask

  task automatic t_reset;   // R1
    check("R1 mode", arr_mode, 0);
    check("R1 busy", busy, 0);
    check("R1 mode_valid", mode_valid, 0);
    check("R1 rvalid", cpu_rvalid, 0);
    check("R1 strobes", {arr_rd_stb, arr_prog_stb, arr_erase_stb}, 0);
  endtask

  task automatic t_enable;  // R8
    vpp_ok = 1'b0; reprog_sel = 1'b1;
    bus_write(CMD, 8'h40);
    check("R8 cmd ignored while disabled", arr_mode, 0);
    check("R8 flag low", mode_valid, 0);
    @(negedge clk); vpp_ok = 1'b1;
    @(negedge clk);
    check("R8 flag high", mode_valid, 1);
  endtask

  task automatic t_read;    // R3, R7
    bus_read(12'h010, 1, seed(16'h010), "R3 a");
    bus_read(12'h7A3, 1, seed(16'h7A3), "R3 b");
    bus_read(12'h010, 1, seed(16'h010), "R3 repeat");
    check("R3 mode kept", arr_mode, 0);
    bus_read(CMD, 0, 0, "R7 cmd read");
  endtask

  task automatic t_single;  // R2
    bus_write(CMD, 8'h40); check("R2 program", arr_mode, 1);
    bus_write(CMD, 8'hC0); check("R2 prog-verify", arr_mode, 2);
    bus_write(CMD, 8'hA0); check("R2 erase-verify", arr_mode, 4);
    bus_write(CMD, 8'h33); check("R6 undefined code", arr_mode, 4);
    bus_write(CMD, 8'h00); check("R2 read", arr_mode, 0);
  endtask

  task automatic t_verify;  // R11
    bus_write(CMD, 8'hC0);
    bus_read(12'h222, 1, seed(16'h222), "R11 pvfy");
    check("R11 mode kept", arr_mode, 2);
    bus_write(CMD, 8'hA0);
    bus_read(12'h0FE, 1, seed(16'h0FE), "R11 evfy");
    check("R11 evfy mode kept", arr_mode, 4);
  endtask

  task automatic t_prog;    // R10
    bus_write(CMD, 8'h40);
    bus_write(12'h123, 8'hA7);
    check("R10 prog strobe", arr_prog_stb, 1);
    check("R10 prog addr", arr_addr, 12'h123);
    check("R10 prog data", arr_wdata, 8'hA7);
    check("R10 busy", busy, 1);
    bus_write(CMD, 8'hC0);
    check("R10 cmd ignored while busy", arr_mode, 1);
    wait_idle("R10");
    check("R10 back to read", arr_mode, 0);
    bus_read(12'h123, 1, 8'hA7, "R10 readback");
  endtask

  task automatic t_erase;   // R4
    bus_write(CMD, 8'h20);
    check("R4 single no strobe", arr_erase_stb, 0);
    check("R4 single no mode", arr_mode, 0);
    bus_write(CMD, 8'h20);
    check("R4 erase strobe", arr_erase_stb, 1);
    check("R4 erase mode", arr_mode, 3);
    check("R4 erase busy", busy, 1);
    wait_idle("R4");
    bus_read(12'h010, 1, 8'hFF, "R4 erased");
  endtask

  task automatic t_pairs;   // R5, R6
    bus_write(CMD, 8'h20);
    bus_write(CMD, 8'hC0);
    check("R6 new code decoded", arr_mode, 2);
    bus_write(CMD, 8'h20);
    check("R6 pending dropped", arr_erase_stb, 0);
    check("R6 mode kept", arr_mode, 2);
    bus_write(CMD, 8'hFF);
    bus_write(CMD, 8'h40);
    check("R6 reset half dropped", arr_mode, 1);
    bus_write(CMD, 8'hFF);
    check("R5 single reset", arr_mode, 1);
    bus_write(CMD, 8'hFF);
    check("R5 double reset", arr_mode, 0);
  endtask

  task automatic t_drop;    // R8, R9
    bus_write(CMD, 8'h40);
    @(negedge clk); vpp_ok = 1'b0;
    @(negedge clk);
    check("R9 forced read", arr_mode, 0);
    check("R9 flag cleared", mode_valid, 0);
    bus_write(CMD, 8'hC0);
    check("R8 ignored after drop", arr_mode, 0);
    reprog_sel = 1'b0;
    bus_read(12'h011, 1, 8'hFF, "R9 plain read");
    reprog_sel = 1'b1; vpp_ok = 1'b1;
    bus_write(CMD, 8'h20);
    vpp_ok = 1'b0;
    @(negedge clk); vpp_ok = 1'b1;
    @(negedge clk);
    bus_write(CMD, 8'h20);
    check("R9 pending cleared", arr_erase_stb, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_enable();
    t_read();
    t_single();
    t_verify();
    t_prog();
    t_erase();
    t_pairs();
    t_drop();
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL all watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule